// File: doc/BRIEF.md
# Bridge Data Parity Error Reporter

This block decides, for a bridge joining a primary and a secondary PCI bus, when to pull each bus's active-low data parity error output. For each bus it receives the state of a data phase: whether one completes this cycle, what part the bridge plays in it, and whether the data parity check failed. It also receives the two parity-error-response enables. When a check fails, the bridge's part on that bus allows a report, and that bus's enable is set, the output for that bus goes low for one clock. The output lags the data phase so that it matches the bus protocol's parity error timing.

The block also returns an error found at the far end of a delayed write. While the bridge finishes a delayed write as initiator on one bus, it watches that bus's parity error signal. If the signal is low, the block holds a one-bit pending flag for the originating bus. The next delayed-write data phase on the originating bus, where the bridge is target, consumes the flag and reports the error there. Posted writes are never relayed, because the originator of a posted write has already finished its transaction.

Top module: `bpe_perr_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, both `pri_perr_n` and `sec_perr_n` are 1, and no relay flag is pending.
- R2: A data phase on a bus reports a local parity error when all of these hold in the same cycle: `*_dvld` is 1, `*_par_bad` is 1, that bus's enable is 1, and `*_kind` is 1 (bridge is target of a posted write), 2 (bridge is target of a delayed write) or 3 (bridge is initiator of a read).
- R3: With `*_kind` = 0 (the bridge is in any other part, such as initiator of a write), a failed parity check causes no report on either output.
- R4: When a bus's enable is 0 in the cycle of a trigger, that trigger never reaches the output.
- R5: A trigger sampled at rising edge E0 drives the output low from edge E1 until edge E2, which is one clock. With the default latency of 2, bus agents sample it at E2, two clocks after the data phase.
- R6: `sec_dwc_obs`=1 with `sec_dwc_perr_n`=0 sets the primary relay flag. The next primary data phase with `pri_kind`=2 produces a primary report, with good parity or bad, and clears the flag.
- R7: `pri_dwc_obs`=1 with `pri_dwc_perr_n`=0 sets the secondary relay flag, and the flag is handled in the same way through a secondary data phase with `sec_kind`=2.
- R8: Setting or holding a relay flag does not drive any output by itself. A far parity error signal of 1 sets no flag. Data phases of kind 0, 1 or 3 leave a pending flag in place.
- R9: A kind-2 data phase clears the pending flag even when that bus's enable is 0. The relayed error is then dropped and no later phase reports it.
- R10: The two buses report independently, including in the same cycle.
- R11: Triggers in consecutive cycles give output low in consecutive cycles, one low cycle per trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pri_rsp_en | input | 1 | Parity error response enable, primary side |
| sec_rsp_en | input | 1 | Parity error response enable, secondary side |
| pri_dvld | input | 1 | A primary data phase completes this cycle |
| pri_kind | input | 2 | Bridge part on primary: 0 other, 1 target posted write, 2 target delayed write, 3 initiator read |
| pri_par_bad | input | 1 | Primary data parity check failed |
| sec_dvld | input | 1 | A secondary data phase completes this cycle |
| sec_kind | input | 2 | Bridge part on secondary, encoded as for `pri_kind` |
| sec_par_bad | input | 1 | Secondary data parity check failed |
| pri_dwc_obs | input | 1 | Primary parity error signal is being watched during an upstream delayed write completion |
| pri_dwc_perr_n | input | 1 | Sampled primary parity error signal, active low |
| sec_dwc_obs | input | 1 | Secondary parity error signal is being watched during a downstream delayed write completion |
| sec_dwc_perr_n | input | 1 | Sampled secondary parity error signal, active low |
| pri_perr_n | output | 1 | Primary data parity error output, active low |
| sec_perr_n | output | 1 | Secondary data parity error output, active low |

## Verification
The bench applies a failed parity check under each of the four bridge-part codes on each bus. This shows which parts may report and which may not. The same pattern is repeated with the enable cleared, to separate the masked case from the reporting case. The relay path is driven in these ways:
- a far error followed by a delayed-write phase;
- a far signal that stays high;
- a flag held across posted, read and other phases before it is consumed;
- a flag consumed while the enable is off.

These show whether the flag is set, held and cleared at the right events. Simultaneous and back-to-back triggers show whether the two buses stay independent and whether each report takes exactly one clock at the right latency.

// File: rtl/bpe_pkg.sv
package bpe_pkg;

    // Part the bridge plays in the current data phase on one bus.
    typedef enum logic [1:0] {
        XK_OTHER      = 2'd0,
        XK_TGT_WR_PST = 2'd1,
        XK_TGT_WR_DLY = 2'd2,
        XK_INI_RD     = 2'd3
    } xfer_kind_e;

    // Registered state of one relay flag.
    typedef struct packed {
        logic pend;
    } relay_st_t;

    localparam int unsigned NUM_BUS = 2;
    localparam int unsigned BUS_PRI = 0;
    localparam int unsigned BUS_SEC = 1;

endpackage

// File: rtl/bpe_relay_flag.sv
module bpe_relay_flag
    import bpe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic far_obs_i,
    input  logic far_perr_n_i,
    input  logic consume_i,
    output logic pend_o
);

    relay_st_t st_d, st_q;
    logic      set_w;

    always_comb begin
        set_w = far_obs_i && !far_perr_n_i;
        st_d  = st_q;
        if (consume_i) begin
            st_d.pend = 1'b0;
        end
        if (set_w) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    AST_RELAY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (consume_i && !set_w) |=> !pend_o); // R6

    AST_RELAY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !consume_i) |=> pend_o); // R8

endmodule

// File: rtl/bpe_qualify.sv
module bpe_qualify
    import bpe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dvld_i,
    input  logic [1:0] kind_i,
    input  logic       par_bad_i,
    input  logic       pend_i,
    input  logic       en_i,
    output logic       fire_o,
    output logic       consume_o
);

    xfer_kind_e kind_w;
    logic       role_ok_w;
    logic       local_w;
    logic       relay_w;

    always_comb begin
        kind_w    = xfer_kind_e'(kind_i);
        role_ok_w = (kind_w == XK_TGT_WR_PST) || (kind_w == XK_TGT_WR_DLY) ||
                    (kind_w == XK_INI_RD);
        consume_o = dvld_i && (kind_w == XK_TGT_WR_DLY);
        local_w   = dvld_i && role_ok_w && par_bad_i;
        relay_w   = consume_o && pend_i;
        fire_o    = en_i && (local_w || relay_w);
    end

    AST_EN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !fire_o); // R4

    AST_ROLE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (kind_i == 2'd0) |-> !fire_o); // R3

endmodule

// File: rtl/bpe_delay_line.sv
module bpe_delay_line #(
    parameter int unsigned LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic out_n_o
);

    typedef struct packed {
        logic [LAT-1:0] pipe;
    } line_st_t;

    line_st_t st_d, st_q;

    generate
        if (LAT == 1) begin : g_single
            always_comb begin
                st_d      = st_q;
                st_d.pipe = fire_i;
            end
        end else begin : g_shift
            always_comb begin
                st_d      = st_q;
                st_d.pipe = {st_q.pipe[LAT-2:0], fire_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_n_o = !st_q.pipe[LAT-1];

endmodule

// File: rtl/bpe_perr_unit.sv
module bpe_perr_unit
    import bpe_pkg::*;
#(
    parameter int unsigned PERR_LAT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pri_rsp_en,
    input  logic       sec_rsp_en,
    input  logic       pri_dvld,
    input  logic [1:0] pri_kind,
    input  logic       pri_par_bad,
    input  logic       sec_dvld,
    input  logic [1:0] sec_kind,
    input  logic       sec_par_bad,
    input  logic       pri_dwc_obs,
    input  logic       pri_dwc_perr_n,
    input  logic       sec_dwc_obs,
    input  logic       sec_dwc_perr_n,
    output logic       pri_perr_n,
    output logic       sec_perr_n
);

    logic [NUM_BUS-1:0]      en_w, dvld_w, bad_w, obs_w, fperr_n_w;
    logic [NUM_BUS-1:0][1:0] kind_w;
    logic [NUM_BUS-1:0]      pend_w, fire_w, consume_w, out_n_w;

    always_comb begin
        en_w[BUS_PRI]      = pri_rsp_en;
        en_w[BUS_SEC]      = sec_rsp_en;
        dvld_w[BUS_PRI]    = pri_dvld;
        dvld_w[BUS_SEC]    = sec_dvld;
        kind_w[BUS_PRI]    = pri_kind;
        kind_w[BUS_SEC]    = sec_kind;
        bad_w[BUS_PRI]     = pri_par_bad;
        bad_w[BUS_SEC]     = sec_par_bad;
        obs_w[BUS_PRI]     = pri_dwc_obs;
        obs_w[BUS_SEC]     = sec_dwc_obs;
        fperr_n_w[BUS_PRI] = pri_dwc_perr_n;
        fperr_n_w[BUS_SEC] = sec_dwc_perr_n;
    end

    // One reporting lane per bus; each lane's relay flag listens to the other bus.
    for (genvar b = 0; b < NUM_BUS; b++) begin : g_lane
        localparam int unsigned FAR = NUM_BUS - 1 - b;

        bpe_relay_flag u_relay (
            .clk          (clk),
            .rst_n        (rst_n),
            .far_obs_i    (obs_w[FAR]),
            .far_perr_n_i (fperr_n_w[FAR]),
            .consume_i    (consume_w[b]),
            .pend_o       (pend_w[b])
        );

        bpe_qualify u_qual (
            .clk       (clk),
            .rst_n     (rst_n),
            .dvld_i    (dvld_w[b]),
            .kind_i    (kind_w[b]),
            .par_bad_i (bad_w[b]),
            .pend_i    (pend_w[b]),
            .en_i      (en_w[b]),
            .fire_o    (fire_w[b]),
            .consume_o (consume_w[b])
        );

        bpe_delay_line #(.LAT(PERR_LAT)) u_line (
            .clk     (clk),
            .rst_n   (rst_n),
            .fire_i  (fire_w[b]),
            .out_n_o (out_n_w[b])
        );
    end

    assign pri_perr_n = out_n_w[BUS_PRI];
    assign sec_perr_n = out_n_w[BUS_SEC];

    AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pri_perr_n && sec_perr_n)); // R1

    AST_RST_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pend_w == '0)); // R1

endmodule

// File: tb/bpe_perr_unit_tb_top.sv
`timescale 1ns/1ps
module bpe_perr_unit_tb_top;

    logic clk = 1'b0;
    logic rst_n;
    logic pri_rsp_en, sec_rsp_en;
    logic pri_dvld, pri_par_bad, sec_dvld, sec_par_bad;
    logic [1:0] pri_kind, sec_kind;
    logic pri_dwc_obs, pri_dwc_perr_n, sec_dwc_obs, sec_dwc_perr_n;
    logic pri_perr_n, sec_perr_n;

    int checks = 0;
    int errs   = 0;

    always #2 clk = ~clk;

    bpe_perr_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .pri_rsp_en(pri_rsp_en), .sec_rsp_en(sec_rsp_en),
        .pri_dvld(pri_dvld), .pri_kind(pri_kind), .pri_par_bad(pri_par_bad),
        .sec_dvld(sec_dvld), .sec_kind(sec_kind), .sec_par_bad(sec_par_bad),
        .pri_dwc_obs(pri_dwc_obs), .pri_dwc_perr_n(pri_dwc_perr_n),
        .sec_dwc_obs(sec_dwc_obs), .sec_dwc_perr_n(sec_dwc_perr_n),
        .pri_perr_n(pri_perr_n), .sec_perr_n(sec_perr_n)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic clear_in();
        pri_dvld = 0; pri_kind = 0; pri_par_bad = 0;
        sec_dvld = 0; sec_kind = 0; sec_par_bad = 0;
        pri_dwc_obs = 0; pri_dwc_perr_n = 1;
        sec_dwc_obs = 0; sec_dwc_perr_n = 1;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // One data phase on each bus; checks output before, during and after the report slot (R5).
    task automatic phase(input logic pv, input logic [1:0] pk, input logic pb,
                         input logic sv, input logic [1:0] sk, input logic sb,
                         input logic pexp, input logic sexp, input string tag);
        pri_dvld = pv; pri_kind = pk; pri_par_bad = pb;
        sec_dvld = sv; sec_kind = sk; sec_par_bad = sb;
        step();
        clear_in();
        chk({tag, " R5 pri quiet at E0"}, pri_perr_n, 1'b1);
        chk({tag, " R5 sec quiet at E0"}, sec_perr_n, 1'b1);
        step();
        chk({tag, " pri at E1"}, pri_perr_n, !pexp);
        chk({tag, " sec at E1"}, sec_perr_n, !sexp);
        step();
        chk({tag, " R5 pri released at E2"}, pri_perr_n, 1'b1);
        chk({tag, " R5 sec released at E2"}, sec_perr_n, 1'b1);
    endtask

    // Far-bus observation during a delayed write completion; must not drive outputs (R8).
    task automatic observe(input logic po, input logic ppn, input logic so, input logic spn,
                           input string tag);
        pri_dwc_obs = po; pri_dwc_perr_n = ppn;
        sec_dwc_obs = so; sec_dwc_perr_n = spn;
        step();
        clear_in();
        for (int i = 0; i < 3; i++) begin
            chk({tag, " R8 pri idle after observe"}, pri_perr_n, 1'b1);
            chk({tag, " R8 sec idle after observe"}, sec_perr_n, 1'b1);
            step();
        end
    endtask

    task automatic t_reset();
        rst_n = 0;
        pri_rsp_en = 1; sec_rsp_en = 1;
        clear_in();
        pri_dvld = 1; pri_kind = 2'd3; pri_par_bad = 1;
        repeat (3) step();
        chk("R1 pri high in reset", pri_perr_n, 1'b1);
        chk("R1 sec high in reset", sec_perr_n, 1'b1);
        clear_in();
        rst_n = 1;
        step();
        chk("R1 pri high after reset", pri_perr_n, 1'b1);
        chk("R1 sec high after reset", sec_perr_n, 1'b1);
        // A delayed-write phase must find no pending relay after reset.
        phase(1, 2'd2, 0, 1, 2'd2, 0, 0, 0, "R1 no pending relay");
    endtask

    task automatic t_roles();
        for (int k = 1; k < 4; k++) begin
            phase(1, k[1:0], 1, 0, 2'd0, 0, 1, 0, $sformatf("R2 pri kind %0d", k));
            phase(0, 2'd0, 0, 1, k[1:0], 1, 0, 1, $sformatf("R2 sec kind %0d", k));
        end
        phase(1, 2'd3, 0, 1, 2'd3, 0, 0, 0, "R2 good parity silent");
        phase(1, 2'd0, 1, 1, 2'd0, 1, 0, 0, "R3 kind 0 silent");
        phase(0, 2'd3, 1, 0, 2'd3, 1, 0, 0, "R2 no data phase silent");
    endtask

    task automatic t_enable();
        pri_rsp_en = 0;
        phase(1, 2'd1, 1, 1, 2'd1, 1, 0, 1, "R4 pri masked");
        pri_rsp_en = 1; sec_rsp_en = 0;
        phase(1, 2'd3, 1, 1, 2'd3, 1, 1, 0, "R4 sec masked");
        sec_rsp_en = 1;
    endtask

    task automatic t_relay();
        observe(0, 1, 1, 0, "R6 set pri flag");
        phase(1, 2'd2, 0, 0, 2'd0, 0, 1, 0, "R6 pri relay reported");
        phase(1, 2'd2, 0, 0, 2'd0, 0, 0, 0, "R6 pri flag cleared");
        observe(1, 0, 0, 1, "R7 set sec flag");
        phase(0, 2'd0, 0, 1, 2'd2, 0, 0, 1, "R7 sec relay reported");
        phase(0, 2'd0, 0, 1, 2'd2, 0, 0, 0, "R7 sec flag cleared");
    endtask

    task automatic t_no_relay();
        observe(0, 1, 1, 1, "R8 far signal high");
        phase(1, 2'd2, 0, 0, 2'd0, 0, 0, 0, "R8 no flag from high signal");
        observe(0, 1, 1, 0, "R8 set pri flag");
        phase(1, 2'd1, 0, 0, 2'd0, 0, 0, 0, "R8 posted phase not relayed");
        phase(1, 2'd3, 0, 0, 2'd0, 0, 0, 0, "R8 read phase not relayed");
        phase(1, 2'd0, 0, 0, 2'd0, 0, 0, 0, "R8 other phase not relayed");
        phase(1, 2'd2, 0, 0, 2'd0, 0, 1, 0, "R8 flag held until delayed write");
    endtask

    task automatic t_drop();
        observe(0, 1, 1, 0, "R9 set pri flag");
        pri_rsp_en = 0;
        phase(1, 2'd2, 0, 0, 2'd0, 0, 0, 0, "R9 consumed while masked");
        pri_rsp_en = 1;
        phase(1, 2'd2, 0, 0, 2'd0, 0, 0, 0, "R9 dropped relay stays silent");
    endtask

    task automatic t_both();
        phase(1, 2'd1, 1, 1, 2'd3, 1, 1, 1, "R10 both buses together");
        phase(1, 2'd3, 1, 1, 2'd0, 1, 1, 0, "R10 only primary");
    endtask

    task automatic t_b2b();
        pri_dvld = 1; pri_kind = 2'd3; pri_par_bad = 1;
        step();
        chk("R11 pri quiet at E0", pri_perr_n, 1'b1);
        step();
        clear_in();
        chk("R11 pri low for first trigger", pri_perr_n, 1'b0);
        step();
        chk("R11 pri low for second trigger", pri_perr_n, 1'b0);
        step();
        chk("R11 pri released after two pulses", pri_perr_n, 1'b1);
        chk("R11 sec untouched", sec_perr_n, 1'b1);
    endtask

    initial begin
        #1;
        t_reset();
        t_roles();
        t_enable();
        t_relay();
        t_no_relay();
        t_drop();
        t_both();
        t_b2b();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule